// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C master from the system clock. A 5-bit period code selects a divider multiplier m from a table inside the block. A mode input selects the standard-mode or the fast-mode period formula. The clock pin is open-drain, so the block only ever pulls it low or lets it go. When the block lets the line go, it watches the line through a two-flop synchronizer. It starts timing the high phase only once the synchronized line reads high. A slow rising edge, or a slave that holds the clock low, therefore lengthens the period by the time the line stays low.

Each unstretched period lasts N + 2 system clocks. N is 2·m in standard mode and floor(1.5·m) in fast mode. The extra two cycles are the latency of the synchronizer that detects the released line. The low phase takes the larger half of N and the high phase takes the smaller half. A one-cycle tick marks each falling edge, so a byte engine can move SDA while SCL is low. The enable input gates the whole generator.

Top module: `scl_clock_gen`

## Requirements
- R1: The multiplier is m = MinMult + code·MultStep, where code is periodSel read as an unsigned number. The defaults are MinMult = 80 and MultStep = 4, and MinMult must be at least 3. Every one of the 32 codes gives a legal m.
- R2: With fastMode = 0 and the line free to rise at once, the distance between two consecutive ticks is 2·m + 2 system clocks.
- R3: With fastMode = 1 and the line free to rise at once, the distance between two consecutive ticks is floor(1.5·m) + 2 system clocks.
- R4: sclPullLow = 1 means the line is pulled low. In each period, sclPullLow stays at 1 for exactly ceil(N/2) consecutive cycles, starting at the tick.
- R5: After release, the block does not pull low again until the synchronized line has been seen high and floor(N/2) high cycles have been counted. The detect cycle counts as the first of those high cycles. A line that stays low for d extra cycles after release lengthens the period by exactly d.
- R6: tick is high for exactly one cycle, in the first cycle of each low phase, and at no other time.
- R7: While enable is low, sclPullLow and tick are 0 from the next cycle on. A new enable starts a low phase, with its tick, in the cycle after enable is first sampled high.
- R8: After reset, sclPullLow and tick are 0.
- R9: periodSel and fastMode are sampled only when a low phase begins. A change made in the middle of a period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator while high |
| fastMode | input | 1 | 1 selects the fast-mode period formula |
| periodSel | input | SelW (5) | Period code that selects m |
| sclIn | input | 1 | Level read back from the SCL line |
| sclPullLow | output | 1 | 1 pulls SCL low; 0 releases the line |
| tick | output | 1 | One-cycle pulse on each SCL falling edge |

## Verification
Two things can land in the same cycle: the start of a new period, when the settings are latched and a tick is raised, and an external event. That event is either a drop of enable or a change of periodSel. The bench sweeps the drop of enable across every cycle offset of a short period, so that it meets the low-phase entry, the wait for the line, and the last high cycle. It also changes the period code just after a tick. A behavioural model checks that disable always wins over the start of a period. The model also checks that a code change appears only in the period after the one in progress.

// File: rtl/scl_clock_gen_pkg.sv
package scl_clock_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_HIGH
  } sclPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLen;    // latch the phase lengths for a new period
    logic cntClr;     // counter back to zero
    logic cntInc;     // counter plus one
    logic cntSetOne;  // detect cycle already counts as first high cycle
  } sclStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lowDone;
    logic highDone;
    logic lineHigh;
    logic highIsOne;
  } sclStatus_t;

endpackage

// File: rtl/scl_clock_gen_dp.sv
module scl_clock_gen_dp
  import scl_clock_gen_pkg::*;
#(
  parameter int SelW     = 5,
  parameter int MinMult  = 80,
  parameter int MultStep = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fastMode,
  input  logic [SelW-1:0] periodSel,
  input  logic            sclIn,
  input  sclStrobe_t      strobe,
  output sclStatus_t      status
);

  localparam int Codes   = 1 << SelW;
  localparam int MaxMult = MinMult + (Codes - 1) * MultStep;
  localparam int MultW   = $clog2(MaxMult + 1);
  localparam int CntW    = $clog2(2 * MaxMult + 1);

  // code -> multiplier table
  logic [MultW-1:0] multTable [Codes];
  for (genvar g = 0; g < Codes; g++) begin : g_table
    assign multTable[g] = MultW'(MinMult + g * MultStep);
  end

  logic [CntW-1:0] multExt, nSel, lowNext, highNext;
  logic [CntW-1:0] lowLen, highLen, cnt;
  logic            syncA, syncB;

  always_comb begin
    multExt  = CntW'(multTable[periodSel]);
    nSel     = fastMode ? (multExt + (multExt >> 1)) : (multExt << 1);
    highNext = nSel >> 1;
    lowNext  = highNext + CntW'(nSel[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '0;
    end else if (strobe.loadLen) begin
      lowLen  <= lowNext;
      highLen <= highNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.cntClr)    cnt <= '0;
    else if (strobe.cntSetOne) cnt <= CntW'(1);
    else if (strobe.cntInc)    cnt <= cnt + CntW'(1);
  end

  // two-flop synchronizer: the 2-cycle detection overhead
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= sclIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    status.lowDone   = (cnt == lowLen - CntW'(1));
    status.highDone  = (cnt == highLen - CntW'(1));
    status.lineHigh  = syncB;
    status.highIsOne = (highLen == CntW'(1));
  end

endmodule

// File: rtl/scl_clock_gen_ctl.sv
module scl_clock_gen_ctl
  import scl_clock_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  sclStatus_t status,
  output sclStrobe_t strobe,
  output logic       sclPullLow,
  output logic       tick
);

  sclPhase_e state, nextState;
  logic      tickQ;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!enable) begin
      nextState     = ST_IDLE;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState      = ST_LOW;
          strobe.loadLen = 1'b1;
          strobe.cntClr  = 1'b1;
        end
        ST_LOW: begin
          if (status.lowDone) begin
            nextState     = ST_WAIT;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_WAIT: begin
          if (status.lineHigh) begin
            if (status.highIsOne) begin
              nextState      = ST_LOW;
              strobe.loadLen = 1'b1;
              strobe.cntClr  = 1'b1;
            end else begin
              nextState        = ST_HIGH;
              strobe.cntSetOne = 1'b1;
            end
          end
        end
        ST_HIGH: begin
          if (status.highDone) begin
            nextState      = ST_LOW;
            strobe.loadLen = 1'b1;
            strobe.cntClr  = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tickQ <= 1'b0;
    end else begin
      state <= nextState;
      tickQ <= (nextState == ST_LOW) && (state != ST_LOW);
    end
  end

  assign sclPullLow = (state == ST_LOW);
  assign tick       = tickQ;

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_clock_gen_pkg::*;
#(
  parameter int SelW     = 5,
  parameter int MinMult  = 80,
  parameter int MultStep = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            fastMode,
  input  logic [SelW-1:0] periodSel,
  input  logic            sclIn,
  output logic            sclPullLow,
  output logic            tick
);

  sclStrobe_t strobe;
  sclStatus_t status;

  scl_clock_gen_dp #(
    .SelW    (SelW),
    .MinMult (MinMult),
    .MultStep(MultStep)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fastMode (fastMode),
    .periodSel(periodSel),
    .sclIn    (sclIn),
    .strobe   (strobe),
    .status   (status)
  );

  scl_clock_gen_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .status    (status),
    .strobe    (strobe),
    .sclPullLow(sclPullLow),
    .tick      (tick)
  );

endmodule

// File: rtl/scl_clock_gen_checker.sv
module scl_clock_gen_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclPullLow,
  input logic tick
);

  a_r6_tick_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  a_r6_tick_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullLow) |-> tick);

  a_r6_tick_only_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $rose(sclPullLow));

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclPullLow && !tick));

  a_r4_low_not_single: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclPullLow) && enable) |=> sclPullLow);

endmodule

bind scl_clock_gen scl_clock_gen_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .sclPullLow(sclPullLow),
  .tick      (tick)
);

// File: tb/scl_clock_gen_bench.sv
module scl_clock_gen_bench;

  localparam int MinM  = 3;
  localparam int StepM = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       fastMode = 1'b0;
  logic [4:0] periodSel = '0;
  logic       sclIn = 1'b1;
  logic       sclPullLow, tick;

  always #2.5 clk = ~clk;

  scl_clock_gen #(.SelW(5), .MinMult(MinM), .MultStep(StepM)) u_scl_clock_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .fastMode(fastMode),
    .periodSel(periodSel), .sclIn(sclIn), .sclPullLow(sclPullLow), .tick(tick)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R8";
  int    riseDelay = 0;

  function automatic int nOf(int code, bit fast);
    int m = MinM + code * StepM;
    return fast ? (m + m / 2) : (2 * m);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model + line model ----------------
  int  phase = 0;          // 0 idle, 1 low, 2 released, 3 high
  int  rem = 0, lowL = 0, highL = 0;
  bit  tickE = 0;
  bit  ms1 = 0, ms2 = 0;
  bit  enC = 0, lineC = 1, rstC = 0, modeC = 0;
  int  selC = 0;
  int  relCnt = 0;
  longint cyc = 0, tickCyc = 0;
  int  lastPeriod = 0, lastLow = 0, lowRun = 0;

  always @(negedge clk) begin
    cyc++;
    tickE = 0;
    if (!rstC) begin
      phase = 0; ms1 = 0; ms2 = 0;
    end else begin
      if (!enC) phase = 0;
      else begin
        case (phase)
          0: begin
            phase = 1; lowL = (nOf(selC, modeC) + 1) / 2;
            highL = nOf(selC, modeC) / 2; rem = lowL; tickE = 1;
          end
          1: if (rem == 1) phase = 2; else rem--;
          2: if (ms2) begin
               if (highL == 1) begin
                 phase = 1; lowL = (nOf(selC, modeC) + 1) / 2;
                 highL = nOf(selC, modeC) / 2; rem = lowL; tickE = 1;
               end else begin
                 phase = 3; rem = highL - 1;
               end
             end
          default: if (rem == 1) begin
               phase = 1; lowL = (nOf(selC, modeC) + 1) / 2;
               highL = nOf(selC, modeC) / 2; rem = lowL; tickE = 1;
             end else rem--;
        endcase
      end
      ms2 = ms1;
      ms1 = lineC;
    end
    check(curReq, int'(sclPullLow), int'(phase == 1), "model sclPullLow");
    check(curReq, int'(tick), int'(tickE), "model tick");

    // period tracking
    if (tick) begin
      lastPeriod = int'(cyc - tickCyc); lastLow = lowRun; tickCyc = cyc; lowRun = 1;
    end else if (sclPullLow) lowRun++;

    // open-drain line: low when pulled, otherwise high after riseDelay cycles
    if (sclPullLow) begin relCnt = 0; sclIn = 1'b0; end
    else begin relCnt++; sclIn = (relCnt >= riseDelay + 1); end

    lineC = sclIn; enC = enable; rstC = rstN; modeC = fastMode; selC = int'(periodSel);
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic setEn(bit v);
    @(posedge clk); #1 enable = v;
  endtask

  task automatic waitTick();
    @(negedge clk);
    while (!tick) @(negedge clk);
    #1;
  endtask

  task automatic runCase(int code, bit fast, int d, string req);
    int n;
    curReq = req;
    riseDelay = d;
    @(posedge clk); #1 periodSel = 5'(code); fastMode = fast;
    setEn(1);
    waitTick();
    n = nOf(code, fast);
    for (int i = 0; i < 2; i++) begin
      waitTick();
      check(req, lastPeriod, n + 2 + d, $sformatf("period code %0d fast %0d", code, fast));
      check("R4", lastLow, (n + 1) / 2, "low phase length");
      @(negedge clk);
      check("R6", int'(tick), 0, "tick width");
    end
    setEn(0);
    repeat (2) @(negedge clk);
    check("R7", int'(sclPullLow), 0, "released after disable");
    riseDelay = 0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", int'(sclPullLow), 0, "sclPullLow in reset");
    check("R8", int'(tick), 0, "tick in reset");
    @(posedge clk); #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", int'(sclPullLow), 0, "sclPullLow after reset");

    runCase(0, 0, 0, "R2");
    runCase(10, 0, 0, "R1");
    runCase(31, 0, 0, "R2");
    runCase(0, 1, 0, "R3");
    runCase(5, 1, 0, "R1");
    runCase(31, 1, 0, "R3");
    runCase(4, 0, 3, "R5");
    runCase(2, 1, 40, "R5");

    // R7: restart latency
    curReq = "R7";
    @(posedge clk); #1 periodSel = 5'd6; fastMode = 1'b0;
    setEn(1);
    @(negedge clk);
    @(negedge clk);
    check("R7", int'(tick), 1, "tick one cycle after enable sampled");
    check("R7", int'(sclPullLow), 1, "low phase starts after enable");
    repeat (5) @(posedge clk);
    setEn(0);
    @(negedge clk);
    @(negedge clk);
    check("R7", int'(sclPullLow), 0, "mid-period disable releases");

    // R7: disable swept across every offset of a short period
    @(posedge clk); #1 periodSel = 5'd0;
    for (int off = 0; off < 12; off++) begin
      setEn(1);
      repeat (off) @(posedge clk);
      setEn(0);
      repeat (3) @(posedge clk);
    end

    // R9: code change inside a period
    curReq = "R9";
    @(posedge clk); #1 periodSel = 5'd2; fastMode = 1'b0;
    setEn(1);
    waitTick();
    @(posedge clk); #1 periodSel = 5'd7;
    waitTick();
    check("R9", lastPeriod, nOf(2, 0) + 2, "period in progress keeps old code");
    waitTick();
    check("R9", lastPeriod, nOf(7, 0) + 2, "next period uses new code");
    @(posedge clk); #1 fastMode = 1'b1;
    waitTick();
    check("R9", lastPeriod, nOf(7, 0) + 2, "mode change waits for period end");
    waitTick();
    check("R9", lastPeriod, nOf(7, 1) + 2, "mode applies next period");
    setEn(0);
    repeat (4) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule